// File: doc/BRIEF.md
# Indirect Control Register Bridge

This block gives a host a small window of directly addressed registers through which it reaches a larger bank of internal 16-bit control registers. The window holds a launch register, four 16-bit operand registers, a status word and a fixed revision word. The host loads the operands first. It then writes the launch register, whose value carries both the internal index and the transfer direction. That write starts one internal transaction. The busy flag in the status word stays high until the transaction completes, and software polls it.

An internal value of 32 bits occupies an even/odd index pair. A single write transaction to the even index stores both halves. Reading the value back takes two read transactions, one per index, because each read returns 16 bits. Read-modify-write sequences are done by software as a read transaction followed by a write transaction.

The host bus is a plain synchronous register port: address, write enable, write data and a combinational read data path. There is no streaming data path, so no valid/ready handshake exists. The only back-pressure is the busy flag, which software must observe before launching the next transaction.

Top module: `ireg_bridge`

## Requirements
- R1: After reset, every window register at offsets 0 to 4 reads zero, the status word reads zero, and every internal register holds zero.
- R2: Writing window offset 0 while idle starts a transaction. Bit 7 of the written value selects the direction (1 = read, 0 = write). Bits 5:0 select the internal index. Bit 6 and bits 15:8 do not affect the transaction.
- R3: Status bit 0 (busy) is high for exactly LATENCY (default 4) cycles, beginning in the cycle after the launch write; all other status bits read zero.
- R4: A write to offset 0 while busy is high is dropped: offset 0 keeps its value and the running transaction is neither extended nor replaced.
- R5: A write transaction to an even index stores operand 0 at that index and operand 1 at the next (odd) index.
- R6: A write transaction to an odd index stores operand 0 at that index only; every other internal register is unchanged.
- R7: A read transaction loads the internal register at the index into operand 0 (offset 1) on completion and leaves offsets 2 to 4 unchanged.
- R8: The operands are captured when the transaction launches, so host writes to offsets 1 and 2 while busy do not change what gets stored.
- R9: Offsets 1 to 4 read back the last value the host wrote to them, unless a read transaction replaced offset 1. Offset 0 reads back the last accepted launch value.
- R10: Offset 6 reads the constant REVISION (default 16'h02A1) and offset 7 reads zero. Host writes to offsets 5 and 6 change nothing and start no transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Window offset |
| bus_we | input | 1 | Window write strobe |
| bus_wdata | input | 16 | Window write data |
| bus_rdata | output | 16 | Window read data, combinational from bus_addr |

## Verification
The hardest situation to reach is host traffic that arrives while a transaction is in flight. This covers a second launch attempt, which must be dropped, and operand rewrites, which must not leak into the stored value. The stimulus launches a write and issues a competing launch on the very next cycle, then rewrites operand 0 one cycle later. It then counts the remaining busy cycles and reads back both the target index and the index the dropped launch named. Random transactions with stray bits set above the index field complete the picture.

// File: rtl/ireg_pkg.sv
package ireg_pkg;
  localparam int WIN_AW   = 3;
  localparam int REG_W    = 16;
  localparam int DIR_BIT  = 7;
  localparam int BUSY_BIT = 0;
  localparam int N_OPND   = 4;

  typedef enum logic [WIN_AW-1:0] {
    WIN_LAUNCH = 3'd0,
    WIN_OPND0  = 3'd1,
    WIN_OPND1  = 3'd2,
    WIN_OPND2  = 3'd3,
    WIN_OPND3  = 3'd4,
    WIN_STAT   = 3'd5,
    WIN_REV    = 3'd6
  } win_off_e;

  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/ireg_window.sv
module ireg_window
  import ireg_pkg::*;
#(
  parameter logic [REG_W-1:0] REVISION = 16'h02A1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIN_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              busy,
  input  logic              rd_load,
  input  logic [REG_W-1:0]  rd_val,
  output logic              launch,
  output logic [REG_W-1:0]  launch_q,
  output logic [REG_W-1:0]  opnd0_q,
  output logic [REG_W-1:0]  opnd1_q
);
  logic [REG_W-1:0] opnd_q [N_OPND];

  assign launch = bus_we && (bus_addr == WIN_LAUNCH) && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      launch_q <= '0;
      for (int k = 0; k < N_OPND; k++) opnd_q[k] <= '0;
    end else begin
      if (launch) launch_q <= bus_wdata;
      for (int k = 0; k < N_OPND; k++) begin
        if (bus_we && (bus_addr == WIN_AW'(int'(WIN_OPND0) + k)))
          opnd_q[k] <= bus_wdata;
      end
      // a completing read takes priority over a host write to operand 0
      if (rd_load) opnd_q[0] <= rd_val;
    end
  end

  assign opnd0_q = opnd_q[0];
  assign opnd1_q = opnd_q[1];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      WIN_LAUNCH: bus_rdata = launch_q;
      WIN_OPND0:  bus_rdata = opnd_q[0];
      WIN_OPND1:  bus_rdata = opnd_q[1];
      WIN_OPND2:  bus_rdata = opnd_q[2];
      WIN_OPND3:  bus_rdata = opnd_q[3];
      WIN_STAT:   bus_rdata[BUSY_BIT] = busy;
      WIN_REV:    bus_rdata = REVISION;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ireg_seq.sv
module ireg_seq
  import ireg_pkg::*;
#(
  parameter int IDX_W   = 6,
  parameter int LATENCY = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [REG_W-1:0] launch_word,
  input  logic [REG_W-1:0] opnd0,
  input  logic [REG_W-1:0] opnd1,
  output logic             busy,
  output logic             done,
  output logic             is_rd,
  output logic [IDX_W-1:0] idx_q,
  output logic [REG_W-1:0] lo_q,
  output logic [REG_W-1:0] hi_q
);
  localparam int CW = (LATENCY > 1) ? $clog2(LATENCY) : 1;

  logic [CW-1:0] left_q;

  assign done = busy && (left_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      left_q <= '0;
      is_rd  <= 1'b0;
      idx_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (launch) begin
      busy   <= 1'b1;
      left_q <= CW'(LATENCY - 1);
      is_rd  <= (launch_word[DIR_BIT] == DIR_READ);
      idx_q  <= launch_word[IDX_W-1:0];
      lo_q   <= opnd0;
      hi_q   <= opnd1;
    end else if (done) begin
      busy   <= 1'b0;
    end else if (busy) begin
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/ireg_file.sv
module ireg_file
  import ireg_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [IDX_W-1:0] idx,
  input  logic [REG_W-1:0] lo,
  input  logic [REG_W-1:0] hi,
  output logic [REG_W-1:0] rd_val
);
  localparam int DEPTH = 1 << IDX_W;

  logic [REG_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0] idx_pair;
  logic             pair_wr;

  assign idx_pair = {idx[IDX_W-1:1], 1'b1};
  assign pair_wr  = wr && !idx[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < DEPTH; g++) mem[g] <= '0;
    end else begin
      for (int g = 0; g < DEPTH; g++) begin
        if (wr && (idx == IDX_W'(g)))
          mem[g] <= lo;
        else if (pair_wr && (idx_pair == IDX_W'(g)))
          mem[g] <= hi;
      end
    end
  end

  assign rd_val = mem[idx];
endmodule

// File: rtl/ireg_bridge.sv
module ireg_bridge
  import ireg_pkg::*;
#(
  parameter int               IDX_W    = 6,
  parameter int               LATENCY  = 4,
  parameter logic [REG_W-1:0] REVISION = 16'h02A1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIN_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata
);
  logic             launch_w;
  logic [REG_W-1:0] launch_q_w;
  logic [REG_W-1:0] opnd0_w;
  logic [REG_W-1:0] opnd1_w;
  logic             busy_w;
  logic             done_w;
  logic             is_rd_w;
  logic [IDX_W-1:0] idx_w;
  logic [REG_W-1:0] lo_w;
  logic [REG_W-1:0] hi_w;
  logic [REG_W-1:0] rd_val_w;

  ireg_window #(.REVISION(REVISION)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .busy     (busy_w),
    .rd_load  (done_w && is_rd_w),
    .rd_val   (rd_val_w),
    .launch   (launch_w),
    .launch_q (launch_q_w),
    .opnd0_q  (opnd0_w),
    .opnd1_q  (opnd1_w)
  );

  ireg_seq #(.IDX_W(IDX_W), .LATENCY(LATENCY)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch_w),
    .launch_word(bus_wdata),
    .opnd0      (opnd0_w),
    .opnd1      (opnd1_w),
    .busy       (busy_w),
    .done       (done_w),
    .is_rd      (is_rd_w),
    .idx_q      (idx_w),
    .lo_q       (lo_w),
    .hi_q       (hi_w)
  );

  ireg_file #(.IDX_W(IDX_W)) u_file (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (done_w && !is_rd_w),
    .idx   (idx_w),
    .lo    (lo_w),
    .hi    (hi_w),
    .rd_val(rd_val_w)
  );
endmodule

// File: rtl/ireg_bridge_chk.sv
module ireg_bridge_chk
  import ireg_pkg::*;
#(
  parameter int LATENCY = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WIN_AW-1:0] bus_addr,
  input logic              bus_we,
  input logic [REG_W-1:0]  bus_rdata,
  input logic              busy,
  input logic              done,
  input logic              is_rd,
  input logic [REG_W-1:0]  launch_q,
  input logic [REG_W-1:0]  opnd0_q,
  input logic [REG_W-1:0]  rd_val
);
  localparam int RW = $clog2(LATENCY + 1) + 1;

  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= busy ? run_q + 1'b1 : '0;
  end

  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && bus_we && bus_addr == WIN_LAUNCH) |=> busy); // R2
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_q < RW'(LATENCY))); // R3
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == RW'(LATENCY))); // R3
  AST_STATUS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == WIN_STAT) |-> (bus_rdata == {{(REG_W-1){1'b0}}, busy})); // R3
  AST_DROP_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_we && bus_addr == WIN_LAUNCH) |=> $stable(launch_q)); // R4
  AST_READ_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_rd) |=> (opnd0_q == $past(rd_val))); // R7
endmodule

bind ireg_bridge ireg_bridge_chk #(.LATENCY(LATENCY)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_we   (bus_we),
  .bus_rdata(bus_rdata),
  .busy     (busy_w),
  .done     (done_w),
  .is_rd    (is_rd_w),
  .launch_q (launch_q_w),
  .opnd0_q  (opnd0_w),
  .rd_val   (rd_val_w)
);

// File: tb/test_ireg_bridge.sv
`timescale 1ns/1ps
module test_ireg_bridge;
  localparam logic [15:0] REV_EXP = 16'h02A1;
  localparam int          LAT     = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  int checks = 0;
  int failures = 0;

  logic [15:0] mdl [64];
  logic [15:0] opm [4];

  always #2 clk = ~clk;

  ireg_bridge i_ireg_bridge (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    bus_addr = a; bus_we = 1'b0;
    #1;
    v = bus_rdata;
    @(negedge clk);
  endtask

  task automatic poll(output int n);
    logic [15:0] s;
    n = 0;
    for (int k = 0; k < 40; k++) begin
      rd(3'd5, s);
      if (s[0]) n++;
      else break;
    end
  endtask

  // model of a transaction launched with word w and captured operands lo/hi
  function automatic void apply(input logic [15:0] w, input logic [15:0] lo, input logic [15:0] hi);
    int ix = int'(w[5:0]);
    if (w[7]) opm[0] = mdl[ix];
    else begin
      mdl[ix] = lo;
      if (!w[0]) mdl[ix | 1] = hi;
    end
  endfunction

  task automatic txn(input logic [15:0] w, input string req);
    int n;
    wr(3'd0, w);
    poll(n);
    check({req, "/R3 busy cycles"}, 16'(n), 16'(LAT));
    apply(w, opm[0], opm[1]);
  endtask

  task automatic read_idx(input int ix, input logic [15:0] exp, input string req);
    logic [15:0] v;
    txn(16'h0080 | 16'(ix), req);
    rd(3'd1, v);
    check({req, " read"}, v, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n;
    void'($urandom(32'h5EED_0042));
    for (int k = 0; k < 64; k++) mdl[k] = '0;
    for (int k = 0; k < 4; k++) opm[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      check("R1 window reg", v, 16'h0);
    end
    rd(3'd5, v); check("R1 status", v, 16'h0);
    rd(3'd6, v); check("R10 revision", v, REV_EXP);
    rd(3'd7, v); check("R10 unmapped", v, 16'h0);
    wr(3'd1, 16'hFFFF); opm[0] = 16'hFFFF;
    read_idx(9, 16'h0, "R1 internal zero");

    // R5 even-index pair write
    wr(3'd1, 16'h1111); opm[0] = 16'h1111;
    wr(3'd2, 16'h2222); opm[1] = 16'h2222;
    txn(16'h000A, "R5");
    read_idx(10, 16'h1111, "R5 low");
    read_idx(11, 16'h2222, "R5 high");

    // R6 odd-index write touches one entry
    wr(3'd1, 16'h3333); opm[0] = 16'h3333;
    wr(3'd2, 16'h4444); opm[1] = 16'h4444;
    txn(16'h000B, "R6");
    read_idx(11, 16'h3333, "R6 target");
    read_idx(12, 16'h0000, "R6 neighbour above");
    read_idx(10, 16'h1111, "R6 neighbour below");

    // R7 / R9 read leaves offsets 2..4 alone
    wr(3'd2, 16'h7777); opm[1] = 16'h7777;
    wr(3'd3, 16'h5555); opm[2] = 16'h5555;
    wr(3'd4, 16'h6666); opm[3] = 16'h6666;
    read_idx(10, 16'h1111, "R7");
    rd(3'd2, v); check("R7 opnd1 kept", v, 16'h7777);
    rd(3'd3, v); check("R9 opnd2", v, 16'h5555);
    rd(3'd4, v); check("R9 opnd3", v, 16'h6666);

    // R2 stray bits above the index field
    wr(3'd1, 16'hABCD); opm[0] = 16'hABCD;
    wr(3'd2, 16'h0F0F); opm[1] = 16'h0F0F;
    txn(16'hFF54, "R2 write with stray bits");
    read_idx(20, 16'hABCD, "R2 index decode");
    rd(3'd0, v); check("R9 launch readback", v, 16'h0094);

    // R4 / R8 host traffic while busy
    wr(3'd1, 16'h1357);
    wr(3'd2, 16'h2468);
    wr(3'd0, 16'h001E);
    wr(3'd0, 16'h009F);
    wr(3'd1, 16'h9999);
    poll(n);
    check("R4 busy not extended", 16'(n), 16'(LAT - 2));
    rd(3'd0, v); check("R4 launch kept", v, 16'h001E);
    rd(3'd1, v); check("R9 opnd0 host value", v, 16'h9999);
    mdl[30] = 16'h1357; mdl[31] = 16'h2468;
    opm[0] = 16'h9999; opm[1] = 16'h2468;
    read_idx(30, 16'h1357, "R8 captured low");
    read_idx(31, 16'h2468, "R8 captured high");

    // R10 writes to status and revision
    wr(3'd5, 16'hFFFF);
    rd(3'd5, v); check("R10 status write ignored", v, 16'h0);
    wr(3'd6, 16'h0000);
    rd(3'd6, v); check("R10 revision write ignored", v, REV_EXP);
    rd(3'd0, v); check("R10 no launch", v, 16'h0080 | 16'd31);

    // random transactions
    for (int t = 0; t < 200; t++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if (!w[7]) begin
        opm[0] = 16'($urandom);
        opm[1] = 16'($urandom);
        wr(3'd1, opm[0]);
        wr(3'd2, opm[1]);
        txn(w, "R5/R6 random write");
      end else begin
        logic [15:0] e;
        e = mdl[int'(w[5:0])];
        txn(w, "R7 random read");
        rd(3'd1, v);
        check("R7 random read", v, e);
      end
    end
    for (int k = 0; k < 64; k++) read_idx(k, mdl[k], "R2 final sweep");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule